// File: doc/BRIEF.md
# Miss Entry Target Queue

This block is one miss-tracking entry of a non-blocking cache. When a miss is first seen, the entry captures the line address, the access size, a fill flag and an uncacheable flag, together with the request that caused the miss. Later requests to the same line are queued behind it as targets. When the fill returns, the targets are drained from the head one per cycle. Each target holds a 2-bit command, an exclusive-access flag, a flag marking it as coming from the snoop side, and a request tag.

The entry also tracks whether its bus request has been issued, and whether that request asked for exclusive ownership. Suppose a shared read is already on the bus and exclusive requests are queued. A snooped invalidate that arrives then is not added at the tail. It is slotted in just ahead of the first queued target that needs exclusive access. The reads that were already waiting still see the shared data, and the writes come after the invalidation.

Only one command should be asserted per cycle. If several are asserted together, they resolve in this order: allocate, deallocate, add, pop. Issue is evaluated alongside the others.

Top module: `miss_entry_tq`

## Requirements
- R1: Allocate loads the address, size, fill and uncacheable flags. It sets valid and clears in-service and issued-exclusive. It sets the count to 1, places the incoming request at the head with its snoop flag 0, and copies the request's exclusive flag into needs-exclusive.
- R2: An accepted add normally places the new target at the tail and raises the count by 1. The count never exceeds DEPTH.
- R3: After an accepted add, needs-exclusive is the OR of its previous value and the new target's exclusive flag.
- R4: Command encoding is 0 read, 1 write, 2 invalidate, 3 other. A special placement rule applies when all of the following hold: the new target has command 2 and its snoop flag set, the entry is in service, issued-exclusive is 0, and needs-exclusive is 1. The target is then inserted directly ahead of the oldest queued target whose exclusive flag is set. All other targets keep their relative order.
- R5: Under the R4 rule, if no queued target has its exclusive flag set, the invalidate goes to the tail.
- R6: An add is refused if the queue holds DEPTH targets or the entry is not valid. A refused add gives a one-cycle error pulse on the following cycle and changes no state.
- R7: A pop with a non-empty queue removes the head and lowers the count by 1. A pop with an empty queue gives a one-cycle error pulse and changes no state.
- R8: Issue on a valid entry sets in-service and loads issued-exclusive with the current needs-exclusive value.
- R9: Deallocate with a count of 0 clears valid and in-service. With a non-zero count, it gives an error pulse and changes nothing.
- R10: Synchronous active-high reset clears valid, the count, in-service and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_i | input | 1 | Allocate the entry for a new miss |
| alloc_addr_i | input | ADDR_W | Line address of the miss |
| alloc_size_i | input | SIZE_W | Access size |
| alloc_fill_i | input | 1 | Miss fills the cache |
| alloc_uncache_i | input | 1 | Miss is uncacheable |
| dealloc_i | input | 1 | Release the entry |
| add_i | input | 1 | Queue a target |
| add_snoop_i | input | 1 | Added target comes from the snoop side |
| tgt_cmd_i | input | 2 | Command of the allocating or added target |
| tgt_excl_i | input | 1 | Target needs exclusive access |
| tgt_tag_i | input | TAG_W | Request tag of the target |
| pop_i | input | 1 | Remove the head target |
| issue_i | input | 1 | Mark the bus request as issued |
| valid_o | output | 1 | Entry holds a miss |
| in_service_o | output | 1 | Bus request issued |
| issued_excl_o | output | 1 | Issued request asked for exclusive access |
| needs_excl_o | output | 1 | Some target has needed exclusive access |
| count_o | output | CNT_W | Number of queued targets |
| addr_o | output | ADDR_W | Stored address |
| size_o | output | SIZE_W | Stored size |
| fill_o | output | 1 | Stored fill flag |
| uncache_o | output | 1 | Stored uncacheable flag |
| head_cmd_o | output | 2 | Command of the head target |
| head_excl_o | output | 1 | Exclusive flag of the head target |
| head_snoop_o | output | 1 | Snoop flag of the head target |
| head_tag_o | output | TAG_W | Tag of the head target |
| err_o | output | 1 | Refused-command pulse |

## Verification
Directed sequences cover several cases:
- A snooped invalidate lands between queued reads and a later write, which distinguishes mid-queue insertion from tail append.
- The same invalidate arrives after the exclusive targets have been popped, which shows that the fallback goes to the tail.
- An invalidate from the processor side, and one arriving after an exclusive issue, confirm that each gating condition suppresses the special rule.
- A full queue, an empty pop and a deallocate with waiting targets confirm that refusals leave the state intact.

A long run of random one-hot commands then compares the outputs with a list-based model every cycle, and the head is drained to show the full order.

// File: rtl/miss_entry_tq.sv
module miss_entry_tq #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3,
  parameter int TAG_W  = 5,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [SIZE_W-1:0] alloc_size_i,
  input  logic              alloc_fill_i,
  input  logic              alloc_uncache_i,
  input  logic              dealloc_i,
  input  logic              add_i,
  input  logic              add_snoop_i,
  input  logic [1:0]        tgt_cmd_i,
  input  logic              tgt_excl_i,
  input  logic [TAG_W-1:0]  tgt_tag_i,
  input  logic              pop_i,
  input  logic              issue_i,
  output logic              valid_o,
  output logic              in_service_o,
  output logic              issued_excl_o,
  output logic              needs_excl_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              fill_o,
  output logic              uncache_o,
  output logic [1:0]        head_cmd_o,
  output logic              head_excl_o,
  output logic              head_snoop_o,
  output logic [TAG_W-1:0]  head_tag_o,
  output logic              err_o
);

  localparam logic [1:0]       CMD_INV = 2'd2;
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(DEPTH);

  logic [1:0]       q_cmd [DEPTH];
  logic [TAG_W-1:0] q_tag [DEPTH];
  logic [DEPTH-1:0] q_excl, q_snp;
  logic [CNT_W-1:0] cnt, first_x, ins_pos;
  logic valid, in_svc, iss_x, need_x, err;

  wire do_dealloc = !alloc_i && dealloc_i;
  wire do_add     = !alloc_i && !dealloc_i && add_i;
  wire do_pop     = !alloc_i && !dealloc_i && !add_i && pop_i;
  wire do_issue   = !alloc_i && !dealloc_i && issue_i && valid;
  wire dealloc_ok = do_dealloc && cnt == '0;
  wire add_ok     = do_add && valid && cnt < FULL;
  wire pop_ok     = do_pop && cnt != '0;
  wire special    = in_svc && !iss_x && need_x && add_snoop_i && tgt_cmd_i == CMD_INV;

  always_comb begin
    first_x = cnt;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (CNT_W'(i) < cnt && q_excl[i]) first_x = CNT_W'(i);
  end

  assign ins_pos = special ? first_x : cnt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (alloc_i) begin
        if (i == 0) begin
          q_cmd[i]  <= tgt_cmd_i;
          q_excl[i] <= tgt_excl_i;
          q_snp[i]  <= 1'b0;
          q_tag[i]  <= tgt_tag_i;
        end
      end else if (add_ok) begin
        if (ins_pos == CNT_W'(i)) begin
          q_cmd[i]  <= tgt_cmd_i;
          q_excl[i] <= tgt_excl_i;
          q_snp[i]  <= add_snoop_i;
          q_tag[i]  <= tgt_tag_i;
        end else if (i > 0 && ins_pos < CNT_W'(i)) begin
          q_cmd[i]  <= q_cmd[(i > 0) ? i - 1 : 0];
          q_excl[i] <= q_excl[(i > 0) ? i - 1 : 0];
          q_snp[i]  <= q_snp[(i > 0) ? i - 1 : 0];
          q_tag[i]  <= q_tag[(i > 0) ? i - 1 : 0];
        end
      end else if (pop_ok && i < DEPTH - 1) begin
        q_cmd[i]  <= q_cmd[(i < DEPTH - 1) ? i + 1 : i];
        q_excl[i] <= q_excl[(i < DEPTH - 1) ? i + 1 : i];
        q_snp[i]  <= q_snp[(i < DEPTH - 1) ? i + 1 : i];
        q_tag[i]  <= q_tag[(i < DEPTH - 1) ? i + 1 : i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      cnt    <= '0;
      in_svc <= 1'b0;
      iss_x  <= 1'b0;
      need_x <= 1'b0;
      err    <= 1'b0;
    end else begin
      err <= (do_dealloc && !dealloc_ok) || (do_add && !add_ok) || (do_pop && !pop_ok);
      if (alloc_i) begin
        valid   <= 1'b1;
        cnt     <= CNT_W'(1);
        in_svc  <= 1'b0;
        iss_x   <= 1'b0;
        need_x  <= tgt_excl_i;
        addr_o  <= alloc_addr_i;
        size_o  <= alloc_size_i;
        fill_o  <= alloc_fill_i;
        uncache_o <= alloc_uncache_i;
      end else if (dealloc_ok) begin
        valid  <= 1'b0;
        in_svc <= 1'b0;
      end else begin
        if (add_ok) begin
          cnt    <= cnt + CNT_W'(1);
          need_x <= need_x | tgt_excl_i;
        end else if (pop_ok) begin
          cnt <= cnt - CNT_W'(1);
        end
        if (do_issue) begin
          in_svc <= 1'b1;
          iss_x  <= need_x;
        end
      end
    end
  end

  assign valid_o       = valid;
  assign in_service_o  = in_svc;
  assign issued_excl_o = iss_x;
  assign needs_excl_o  = need_x;
  assign count_o       = cnt;
  assign head_cmd_o    = q_cmd[0];
  assign head_excl_o   = q_excl[0];
  assign head_snoop_o  = q_snp[0];
  assign head_tag_o    = q_tag[0];
  assign err_o         = err;

endmodule

// File: rtl/miss_entry_tq_chk.sv
module miss_entry_tq_chk #(
  parameter int TAG_W = 5,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_i,
  input logic             dealloc_i,
  input logic             add_i,
  input logic             pop_i,
  input logic             issue_i,
  input logic             tgt_excl_i,
  input logic [TAG_W-1:0] tgt_tag_i,
  input logic             valid_o,
  input logic             in_service_o,
  input logic             issued_excl_o,
  input logic             needs_excl_o,
  input logic [CNT_W-1:0] count_o,
  input logic             head_snoop_o,
  input logic [TAG_W-1:0] head_tag_o,
  input logic             err_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  wire add_only = add_i && !alloc_i && !dealloc_i;
  wire pop_only = pop_i && !alloc_i && !dealloc_i && !add_i;

  AST_ALLOC_INIT: assert property (@(posedge clk) disable iff (rst)
    alloc_i |=> valid_o && count_o == CNT_W'(1) && !in_service_o && !head_snoop_o
                && head_tag_o == $past(tgt_tag_i) && needs_excl_o == $past(tgt_excl_i)); // R1
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count_o <= FULL); // R2
  AST_ADD_COUNT: assert property (@(posedge clk) disable iff (rst)
    (add_only && valid_o && count_o < FULL) |=> count_o == $past(count_o) + CNT_W'(1)); // R2
  AST_EXCL_MERGE: assert property (@(posedge clk) disable iff (rst)
    (add_only && valid_o && count_o < FULL && tgt_excl_i) |=> needs_excl_o); // R3
  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (add_only && count_o == FULL) |=> err_o && count_o == $past(count_o)); // R6
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (pop_only && count_o == '0) |=> err_o && count_o == '0); // R7
  AST_ISSUE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (issue_i && valid_o && !alloc_i && !dealloc_i && !add_i) |=>
      in_service_o && issued_excl_o == $past(needs_excl_o)); // R8
  AST_DEALLOC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (dealloc_i && !alloc_i && count_o == '0) |=> !valid_o && !in_service_o); // R9
endmodule

bind miss_entry_tq miss_entry_tq_chk #(.TAG_W(TAG_W), .DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst(rst), .alloc_i(alloc_i), .dealloc_i(dealloc_i), .add_i(add_i),
  .pop_i(pop_i), .issue_i(issue_i), .tgt_excl_i(tgt_excl_i), .tgt_tag_i(tgt_tag_i),
  .valid_o(valid_o), .in_service_o(in_service_o), .issued_excl_o(issued_excl_o),
  .needs_excl_o(needs_excl_o), .count_o(count_o), .head_snoop_o(head_snoop_o),
  .head_tag_o(head_tag_o), .err_o(err_o));

// File: tb/test_miss_entry_tq.sv
module test_miss_entry_tq;
  localparam int ADDR_W = 32, SIZE_W = 3, TAG_W = 5, DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int OP_IDLE = 0, OP_ALLOC = 1, OP_DEALLOC = 2, OP_ADD = 3, OP_POP = 4, OP_ISSUE = 5;

  logic clk = 0, rst = 1;
  logic alloc_i = 0, dealloc_i = 0, add_i = 0, add_snoop_i = 0, pop_i = 0, issue_i = 0;
  logic [ADDR_W-1:0] alloc_addr_i = '0;
  logic [SIZE_W-1:0] alloc_size_i = '0;
  logic alloc_fill_i = 0, alloc_uncache_i = 0, tgt_excl_i = 0;
  logic [1:0] tgt_cmd_i = '0;
  logic [TAG_W-1:0] tgt_tag_i = '0;
  logic valid_o, in_service_o, issued_excl_o, needs_excl_o, fill_o, uncache_o;
  logic [CNT_W-1:0] count_o;
  logic [ADDR_W-1:0] addr_o;
  logic [SIZE_W-1:0] size_o;
  logic [1:0] head_cmd_o;
  logic head_excl_o, head_snoop_o, err_o;
  logic [TAG_W-1:0] head_tag_o;

  always #2 clk = ~clk;

  miss_entry_tq #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) i_miss_entry_tq (.*);

  // model state
  logic [TAG_W+3:0] mq[$];
  bit m_valid, m_ins, m_iex, m_nex, m_err, m_fill, m_unc;
  logic [ADDR_W-1:0] m_addr;
  logic [SIZE_W-1:0] m_size;
  string tag = "R10", xtag = "R10";
  int vectors = 0, miscompares = 0;

  task automatic chk(string r, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk({tag, " valid"}, valid_o, m_valid);
    chk({tag, " count"}, count_o, mq.size());
    chk({tag, " err"}, err_o, m_err);
    if (m_valid) begin
      chk({tag, " in_service"}, in_service_o, m_ins);
      chk({tag, " issued_excl"}, issued_excl_o, m_iex);
      chk({xtag, " needs_excl"}, needs_excl_o, m_nex);
      chk("R1 addr", addr_o, m_addr);
      chk("R1 size", size_o, m_size);
      chk("R1 flags", {fill_o, uncache_o}, {m_fill, m_unc});
    end
    if (mq.size() > 0)
      chk({tag, " head"}, {head_cmd_o, head_excl_o, head_snoop_o, head_tag_o}, mq[0]);
  endtask

  task automatic step(int op, logic [1:0] cmd = 0, bit ex = 0, bit sn = 0, logic [TAG_W-1:0] t = 0);
    compare();
    alloc_i = op == OP_ALLOC; dealloc_i = op == OP_DEALLOC; add_i = op == OP_ADD;
    pop_i = op == OP_POP; issue_i = op == OP_ISSUE;
    tgt_cmd_i = cmd; tgt_excl_i = ex; add_snoop_i = sn; tgt_tag_i = t;
    alloc_addr_i = $urandom; alloc_size_i = SIZE_W'($urandom);
    alloc_fill_i = 1'($urandom); alloc_uncache_i = 1'($urandom);
    m_err = 0; xtag = "R3";
    case (op)
      OP_ALLOC: begin
        tag = "R1"; xtag = "R1";
        m_valid = 1; m_ins = 0; m_iex = 0; m_nex = ex;
        m_addr = alloc_addr_i; m_size = alloc_size_i; m_fill = alloc_fill_i; m_unc = alloc_uncache_i;
        mq.delete(); mq.push_back({cmd, ex, 1'b0, t});
      end
      OP_DEALLOC: begin
        tag = "R9"; xtag = "R9";
        if (mq.size() == 0) begin m_valid = 0; m_ins = 0; end else m_err = 1;
      end
      OP_ADD: begin
        if (m_valid && mq.size() < DEPTH) begin
          int pos = mq.size();
          tag = "R2";
          if (m_ins && !m_iex && m_nex && sn && cmd == 2'd2) begin
            tag = "R5";
            for (int k = mq.size() - 1; k >= 0; k--)
              if (mq[k][TAG_W+1]) begin pos = k; tag = "R4"; end
          end
          mq.insert(pos, {cmd, ex, sn, t});
          m_nex = m_nex | ex;
        end else begin
          tag = "R6"; xtag = "R6"; m_err = 1;
        end
      end
      OP_POP: begin
        tag = "R7"; xtag = "R7";
        if (mq.size() > 0) void'(mq.pop_front()); else m_err = 1;
      end
      OP_ISSUE: begin
        tag = "R8"; xtag = "R8";
        if (m_valid) begin m_ins = 1; m_iex = m_nex; end
      end
      default: begin tag = "idle"; xtag = "idle"; end
    endcase
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state checked by the first compare
    // R4: reads ahead of a write, invalidate lands between them
    step(OP_ALLOC, 2'd0, 0, 0, 5'd1);
    step(OP_ADD, 2'd0, 0, 0, 5'd2);
    step(OP_ISSUE);
    step(OP_ADD, 2'd1, 1, 0, 5'd3);
    step(OP_ADD, 2'd0, 0, 0, 5'd4);
    step(OP_ADD, 2'd2, 0, 1, 5'd5);
    step(OP_DEALLOC);                 // R9 refused, targets waiting
    repeat (6) step(OP_POP);          // R7 drains, last one empty
    step(OP_DEALLOC);
    // R5: exclusive targets gone, invalidate goes to tail
    step(OP_ALLOC, 2'd0, 0, 0, 5'd6);
    step(OP_ISSUE);
    step(OP_ADD, 2'd1, 1, 0, 5'd7);
    step(OP_POP); step(OP_POP);
    step(OP_ADD, 2'd0, 0, 0, 5'd8);
    step(OP_ADD, 2'd2, 0, 1, 5'd9);
    step(OP_ADD, 2'd2, 0, 0, 5'd10);  // processor-side invalidate: tail
    step(OP_ISSUE);                   // now issued exclusive
    step(OP_ADD, 2'd1, 1, 0, 5'd11);
    step(OP_ADD, 2'd2, 0, 1, 5'd12);  // gated off: tail
    repeat (5) step(OP_POP);
    // R6: fill to DEPTH then one more
    step(OP_ALLOC, 2'd3, 1, 0, 5'd13);
    for (int k = 0; k < DEPTH; k++) step(OP_ADD, 2'd0, 0, 0, TAG_W'(k + 14));
    repeat (DEPTH + 1) step(OP_POP);
    step(OP_DEALLOC);
    step(OP_ADD, 2'd0, 0, 0, 5'd1);   // R6 add to invalid entry
    // random one-hot traffic
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      int op = r < 4 ? OP_ALLOC : r < 10 ? OP_DEALLOC : r < 55 ? OP_ADD :
               r < 80 ? OP_POP : r < 88 ? OP_ISSUE : OP_IDLE;
      step(op, 2'($urandom), 1'($urandom), 1'($urandom), TAG_W'($urandom));
    end
    step(OP_IDLE);
    finish_run();
  end
endmodule